// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O port of up to sixteen pins, reached through a simple word-addressed register bus. Each pin has a direction bit and an output latch. It also has a two-flop input synchronizer. A per-pin trigger detector can fire on a rising edge, a falling edge, both edges, a low level or a high level. Detected events are latched into a status word, gated by a per-pin enable, and masked through separate set and clear strobes. The unmasked status bits are ORed into a single interrupt line.

Bus writes take effect on the rising clock edge while `bus_we` is high. Reads are combinational on `bus_addr`. A soft-reset control word is driven by a two-state machine. In state SR_RUN, writing 1 to bit 0 of word 12 takes the transition RUN_TO_HOLD into SR_HOLD. In SR_HOLD every register is forced to its reset value and all other writes are ignored. Writing 0 to that bit takes the transition HOLD_TO_RUN back to SR_RUN. Any other bus activity keeps the current state.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the enable, status, display, output, direction and mode words read 0 and `irq` is 0. The mask is all ones, so a latched status bit shows neither in the display word nor on `irq` until it is unmasked.
- R2: Direction bit 1 makes a pin an output. `pin_oe` follows the direction word (offset 8) and `pin_out` follows the output word (offset 6). Direction and output bits at or above N_PINS are ignored and read as 0.
- R3: The input word (offset 7) shows a pin change two clock edges after the change and not after one.
- R4: Each pin has a 3-bit trigger code. Pin n below 8 uses bits [4n+2:4n] of word 9, and pin n from 8 up uses bits [4(n-8)+2:4(n-8)] of word 10. Bit 3 of each nibble and nibbles of absent pins read as 0.
- R5: Code 0 is falling edge, 1 rising edge and 4 both edges. A matching edge sets the pin's status bit (offset 1) on the third clock edge after the pin change, and the bit stays set after the pin returns.
- R6: Code 2 is low level and code 3 is high level. While the level is active the status bit is set, and a clear leaves it set. Once the level is gone, a clear removes it. Codes 5 to 7 never set status.
- R7: Status is recorded only for pins whose enable bit (offset 0) is 1.
- R8: Writing 1 to a bit of the clear word (offset 3) clears that status bit, and writing 0 leaves it unchanged. When a new event and a clear occur in the same cycle, the event wins.
- R9: A 1 written to the mask-set word (offset 4) masks a pin, and a 1 written to the mask-clear word (offset 5) unmasks it. Both words read as 0. The display word (offset 2) is status AND NOT mask, and `irq` is 1 exactly when the display word is nonzero.
- R10: Writing 1 to bit 0 of word 12 enters SR_HOLD. Word 12 then reads 1, all registers including status take their reset values, and other writes are ignored. Writing 0 returns to SR_RUN.
- R11: Writes to the status, display and input words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| pin_in | input | N_PINS | Raw pin inputs |
| pin_out | output | N_PINS | Output latch |
| pin_oe | output | N_PINS | Output enable (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes are visible on the read port one clock edge after the write, at the next falling edge. The input word is due two edges after a pin change. Status, display and `irq` are due three edges after a pin change: two synchronizer stages plus the status flop. The bench drives pins and bus signals at falling edges, counts that exact number of rising edges, and samples at the following falling edge. For the synchronizer it also samples one edge early to confirm the old value is still present.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int REG_WORDS = 13;
    localparam int ADDR_W    = $clog2(REG_WORDS);

    localparam logic [ADDR_W-1:0] OFS_IEN  = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_DISP = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_MSET = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_MCLR = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_DOUT = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_DIN  = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_MLO  = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_MHI  = 4'd10;
    localparam logic [ADDR_W-1:0] OFS_SRST = 4'd12;

    localparam int MODE_W   = 3;
    localparam int NIBBLE_W = 4;
    localparam int PINS_PER_MODE_WORD = 8;

    typedef enum logic [MODE_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_mode_e;

    typedef enum logic {
        SR_RUN  = 1'b0,
        SR_HOLD = 1'b1
    } srst_state_e;
endpackage

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_raw,
    input  logic              wipe,
    input  logic              trig_en,
    input  logic              clr_req,
    input  logic [MODE_W-1:0] trig_code,
    output logic              pin_sync,
    output logic              evt,
    output logic              stat
);
    logic s1_q, s2_q, s3_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin_raw;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign pin_sync = s2_q;
    assign rise     = s2_q & ~s3_q;
    assign fall     = ~s2_q & s3_q;

    always_comb begin
        case (trig_code)
            TRIG_FALL: evt = fall;
            TRIG_RISE: evt = rise;
            TRIG_LOW:  evt = ~s2_q;
            TRIG_HIGH: evt = s2_q;
            TRIG_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat <= 1'b0;
        else if (wipe)
            stat <= 1'b0;
        else
            stat <= (stat & ~clr_req) | (evt & trig_en);
    end

    // R8: a clear with no competing event empties the status bit
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(evt && trig_en)) |=> !stat);

    // R7: a disabled pin never gains status
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !stat) |=> !stat);

    // R5: status is sticky until cleared or wiped
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !clr_req && !wipe) |=> stat);
endmodule

// File: rtl/gpio_srst_ctl.sv
module gpio_srst_ctl
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_wr,
    input  logic srst_bit,
    output logic wipe
);
    srst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_RUN:  if (srst_wr && srst_bit)  state_d = SR_HOLD; // RUN_TO_HOLD
            SR_HOLD: if (srst_wr && !srst_bit) state_d = SR_RUN;  // HOLD_TO_RUN
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SR_RUN:  wipe = 1'b0;
            SR_HOLD: wipe = 1'b1;
        endcase
    end

    // R10: writing 1 always lands in the hold state
    a_r10_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_wr && srst_bit) |=> wipe);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    localparam int LO_PINS = (N_PINS < PINS_PER_MODE_WORD) ? N_PINS : PINS_PER_MODE_WORD;

    logic [N_PINS-1:0] ien_q, mask_q, dout_q, dir_q;
    logic [N_PINS-1:0] stat, disp, sync_v, evt_v, clr_v;
    logic [MODE_W-1:0] mode_q [N_PINS];
    logic [N_PINS-1:0] wbits;
    logic              wipe;
    logic              wr_ok;

    assign wbits = bus_wdata[N_PINS-1:0];
    assign wr_ok = bus_we && !wipe;

    gpio_srst_ctl u_srst (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_wr  (bus_we && (bus_addr == OFS_SRST)),
        .srst_bit (bus_wdata[0]),
        .wipe     (wipe)
    );

    assign clr_v = (wr_ok && (bus_addr == OFS_CLR)) ? wbits : '0;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        gpio_pin_detect u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_raw   (pin_in[g]),
            .wipe      (wipe),
            .trig_en   (ien_q[g]),
            .clr_req   (clr_v[g]),
            .trig_code (mode_q[g]),
            .pin_sync  (sync_v[g]),
            .evt       (evt_v[g]),
            .stat      (stat[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            mask_q <= '1;
            dout_q <= '0;
            dir_q  <= '0;
            for (int i = 0; i < N_PINS; i++) mode_q[i] <= '0;
        end else if (wipe) begin
            ien_q  <= '0;
            mask_q <= '1;
            dout_q <= '0;
            dir_q  <= '0;
            for (int i = 0; i < N_PINS; i++) mode_q[i] <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_IEN:  ien_q  <= wbits;
                OFS_MSET: mask_q <= mask_q | wbits;
                OFS_MCLR: mask_q <= mask_q & ~wbits;
                OFS_DOUT: dout_q <= wbits;
                OFS_DIR:  dir_q  <= wbits;
                OFS_MLO:
                    for (int i = 0; i < LO_PINS; i++)
                        mode_q[i] <= bus_wdata[NIBBLE_W*i +: MODE_W];
                OFS_MHI:
                    for (int i = PINS_PER_MODE_WORD; i < N_PINS; i++)
                        mode_q[i] <= bus_wdata[NIBBLE_W*(i-PINS_PER_MODE_WORD) +: MODE_W];
                default: ;
            endcase
        end
    end

    assign disp    = stat & ~mask_q;
    assign irq     = |disp;
    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IEN:  bus_rdata[N_PINS-1:0] = ien_q;
            OFS_STAT: bus_rdata[N_PINS-1:0] = stat;
            OFS_DISP: bus_rdata[N_PINS-1:0] = disp;
            OFS_DOUT: bus_rdata[N_PINS-1:0] = dout_q;
            OFS_DIN:  bus_rdata[N_PINS-1:0] = sync_v;
            OFS_DIR:  bus_rdata[N_PINS-1:0] = dir_q;
            OFS_MLO:
                for (int i = 0; i < LO_PINS; i++)
                    bus_rdata[NIBBLE_W*i +: MODE_W] = mode_q[i];
            OFS_MHI:
                for (int i = PINS_PER_MODE_WORD; i < N_PINS; i++)
                    bus_rdata[NIBBLE_W*(i-PINS_PER_MODE_WORD) +: MODE_W] = mode_q[i];
            OFS_SRST: bus_rdata[0] = wipe;
            default: ;
        endcase
    end

    // R9: bits written to the mask-set word are masked on the next cycle
    a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == OFS_MSET) |=>
        ((mask_q & $past(wbits)) == $past(wbits)));

    // R10: the hold state returns configuration to defaults
    a_r10_hold_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (ien_q == '0 && dir_q == '0 && dout_q == '0 && mask_q == '1));

    // R2: direction writes reach pin_oe one cycle later
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == OFS_DIR) |=> (pin_oe == $past(wbits)));
endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
    import gpio_irq_pkg::*;

    localparam int NP = 12;
    localparam time CLK_P = 20ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pins = '0;
    logic [NP-1:0]     pin_out, pin_oe;
    logic              irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_port #(.N_PINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {mode[2:0], level before, level after, expected status}
    localparam logic [5:0] VEC [12] = '{
        6'b000_1_0_1, 6'b000_0_1_0, 6'b001_0_1_1, 6'b001_1_0_0,
        6'b010_1_0_1, 6'b010_1_1_0, 6'b011_0_1_1, 6'b011_0_0_0,
        6'b100_0_1_1, 6'b100_1_0_1, 6'b101_0_1_0, 6'b111_1_0_0
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        rd(OFS_IEN, v);  chk("R1 ien reset", v, 0);
        rd(OFS_STAT, v); chk("R1 status reset", v, 0);
        rd(OFS_DIR, v);  chk("R1 dir reset", v, 0);
        rd(OFS_MLO, v);  chk("R1 mode reset", v, 0);
        chk("R1 irq reset", {31'b0, irq}, 0);

        // R2 direction and output, upper bits dropped
        wr(OFS_DIR, 32'hFFFF_F5A5);
        rd(OFS_DIR, v); chk("R2 dir width", v, 32'h5A5);
        chk("R2 pin_oe", {20'b0, pin_oe}, 32'h5A5);
        wr(OFS_DOUT, 32'hFFFF_F0C3);
        chk("R2 pin_out", {20'b0, pin_out}, 32'h0C3);

        // R4 nibble layout
        wr(OFS_MLO, 32'hFFFF_FFFF);
        rd(OFS_MLO, v); chk("R4 mode low", v, 32'h7777_7777);
        wr(OFS_MHI, 32'hFFFF_FFFF);
        rd(OFS_MHI, v); chk("R4 mode high", v, 32'h0000_7777);
        wr(OFS_MHI, 32'h0000_0350);
        rd(OFS_MHI, v); chk("R4 mode high pattern", v, 32'h0000_0350);
        wr(OFS_MHI, 0);

        // R3 two-flop synchronizer timing
        @(negedge clk); bus_addr = OFS_DIN; pins = 12'h801;
        @(negedge clk); chk("R3 one edge old", bus_rdata, 0);
        @(negedge clk); chk("R3 two edges new", bus_rdata, 32'h801);
        pins = '0;
        settle(4);

        // R5 R6 mode table on pin 3
        for (int k = 0; k < 12; k++) begin
            wr(OFS_IEN, 0);
            wr(OFS_MLO, {17'b0, VEC[k][5:3], 12'b0});
            @(negedge clk); pins[3] = VEC[k][2];
            settle(5);
            wr(OFS_CLR, 32'h8);
            wr(OFS_IEN, 32'h8);
            @(negedge clk); pins[3] = VEC[k][1];
            repeat (3) @(posedge clk);
            @(negedge clk); #1;
            bus_addr = OFS_STAT; #1;
            chk($sformatf("R5 R6 table entry %0d mode %0d", k, VEC[k][5:3]),
                {31'b0, bus_rdata[3]}, {31'b0, VEC[k][0]});
        end
        wr(OFS_IEN, 0); pins = '0; settle(4); wr(OFS_CLR, 32'hFFF);

        // R5 exact latency plus stickiness, R1 mask hides it
        wr(OFS_MLO, 32'h0000_0001); wr(OFS_IEN, 32'h1);
        @(negedge clk); bus_addr = OFS_STAT; pins[0] = 1'b1;
        @(negedge clk); @(negedge clk); chk("R5 not before third edge", bus_rdata, 0);
        @(negedge clk); chk("R5 set on third edge", bus_rdata, 1);
        pins[0] = 1'b0; settle(4);
        rd(OFS_STAT, v); chk("R5 sticky after return", v, 1);
        rd(OFS_DISP, v); chk("R1 masked display", v, 0);
        chk("R1 masked irq", {31'b0, irq}, 0);

        // R9 mask clear/set strobes
        wr(OFS_MCLR, 32'h1);
        rd(OFS_DISP, v); chk("R9 unmasked display", v, 1);
        chk("R9 irq high", {31'b0, irq}, 1);
        rd(OFS_MCLR, v); chk("R9 strobe reads 0", v, 0);
        wr(OFS_MSET, 32'h1);
        chk("R9 irq masked again", {31'b0, irq}, 0);
        wr(OFS_MCLR, 32'h1);

        // R11 read-only words ignore writes
        wr(OFS_STAT, 0); wr(OFS_DISP, 0);
        rd(OFS_STAT, v); chk("R11 status write ignored", v, 1);

        // R8 clear with zeros does nothing, with one clears
        wr(OFS_CLR, 32'hFFE);
        rd(OFS_STAT, v); chk("R8 zero bit no effect", v, 1);
        wr(OFS_CLR, 32'h1);
        rd(OFS_STAT, v); chk("R8 clear takes", v, 0);
        chk("R9 irq drops", {31'b0, irq}, 0);

        // R7 disabled pin does not record
        wr(OFS_IEN, 0);
        @(negedge clk); pins[0] = 1'b1; settle(5);
        rd(OFS_STAT, v); chk("R7 disabled no status", v, 0);

        // R6 level persists through clear
        wr(OFS_MLO, 32'h0000_0003); wr(OFS_IEN, 32'h1); settle(2);
        rd(OFS_STAT, v); chk("R6 high level sets", v, 1);
        wr(OFS_CLR, 32'h1);
        rd(OFS_STAT, v); chk("R6 clear while level held", v, 1);
        @(negedge clk); pins[0] = 1'b0; settle(4);
        wr(OFS_CLR, 32'h1);
        rd(OFS_STAT, v); chk("R6 clear after level gone", v, 0);

        // R10 soft reset hold and release
        wr(OFS_DIR, 32'hABC); wr(OFS_IEN, 32'h1); wr(OFS_MCLR, 32'h1);
        wr(OFS_MLO, 32'h0000_0002); settle(3);
        wr(OFS_SRST, 1);
        rd(OFS_SRST, v); chk("R10 hold reads 1", v, 1);
        wr(OFS_DIR, 32'h5);
        rd(OFS_DIR, v); chk("R10 write ignored in hold", v, 0);
        wr(OFS_SRST, 0);
        rd(OFS_SRST, v); chk("R10 released", v, 0);
        rd(OFS_IEN, v); chk("R10 ien default", v, 0);
        rd(OFS_MLO, v); chk("R10 mode default", v, 0);
        rd(OFS_STAT, v); chk("R10 status wiped", v, 0);
        chk("R10 pin_oe default", {20'b0, pin_oe}, 0);
        wr(OFS_DIR, 32'h5);
        rd(OFS_DIR, v); chk("R10 writes resume", v, 5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule